// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block sits next to a floating-point datapath and handles its exception reporting. Each time an operation completes, the datapath raises `op_valid` and reports what happened: a denormalized operand, an invalid operation, a division by zero, overflow, underflow or an inexact result. It also reports which of overflow, underflow and inexact the operation could have produced at all, and whether the operation belongs to the matrix-transform class. In the same cycle the unit decides whether to raise its single trap request. A trap holds back the destination write. When there is no trap, the unit provides the default result for an untrapped invalid or divide-by-zero case.

A 16-bit status/control register holds three fields. The cause field reports only the most recent operation. The sticky flag field collects events until software writes it. The enable field selects which conditions trap. An extra error source, a denormal operand seen while flushing is off, has a cause bit but no flag or enable bit, so it can never be masked. Software reads and writes the register through a plain CPU-side port. Because only one trap line exists, software finds the reason by reading the register.

Top module: `fp_exc_unit`

## Requirements
- R1: After a synchronous reset, the whole status register (cause, flag and enable) reads as zero.
- R2: Source bits in `ev_src`, `may_src` and the register fields use this order: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. The register layout is: flag at [4:0], enable at [9:5], cause at [15:10], with the error cause at bit 15. On a cycle with `op_valid` high, each cause bit is set to 1 if its source occurred and cleared to 0 if not. Without `op_valid` and without a CPU write, the cause field keeps its value.
- R3: A flag bit becomes 1 when its source occurs during a completing operation and otherwise keeps its value. Only a CPU write clears it.
- R4: When `dn_mode` is 0 and `ev_denorm` is 1 on a completing operation, the error cause bit is set and `trap_req` is raised, whatever the enable field holds. When `dn_mode` is 1, a denormal input sets no error cause and causes no trap.
- R5: Invalid and divide-by-zero trap only when their enable bit is 1 and their event is present. Overflow, underflow and inexact trap when their enable bit is 1 and either the event or the matching `may_src` bit is present. With the enable bit at 0, none of these sources traps.
- R6: With the invalid enable bit set, an operation with `op_xform` high traps even without an invalid event. In that case the invalid cause bit stays 0. In the same way, a possible-only overflow, underflow or inexact trap leaves its cause bit at 0.
- R7: `trap_req` is the only trap output and is combinational in the cycle of `op_valid`. `dest_we` equals `op_valid` with no trap, so a trap always suppresses the destination write. `trap_req` is 0 while `op_valid` is 0.
- R8: An untrapped invalid event drives `dflt_valid` high with `dflt_data` = 0x7FC00000. Invalid takes precedence over divide-by-zero.
- R9: An untrapped divide-by-zero event without an invalid event drives `dflt_valid` high with `dflt_data` = 0x7F800000, with bit 31 taken from `res_sign`. A trapping operation never asserts `dflt_valid`.
- R10: When `csr_we` is high, the next register value is `csr_wdata`, even if an operation completes in the same cycle. `csr_rdata` always shows the current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation completes this cycle |
| dn_mode | input | 1 | 1 = denormal inputs are flushed (no error source) |
| ev_denorm | input | 1 | An input operand is denormalized |
| ev_src | input | 5 | Events that occurred (I,U,O,Z,V at bits 0..4) |
| may_src | input | 5 | Events the operation could produce (bits 0..2 used) |
| op_xform | input | 1 | Operation is of the matrix-transform class |
| res_sign | input | 1 | Sign of the unrounded result |
| csr_we | input | 1 | CPU write strobe for the status register |
| csr_wdata | input | 16 | CPU write data |
| csr_rdata | output | 16 | Current status register |
| trap_req | output | 1 | Common floating-point exception request |
| dest_we | output | 1 | Destination register write enable |
| dflt_valid | output | 1 | Default result replaces the datapath result |
| dflt_data | output | 32 | Default result value |

## Verification
`trap_req`, `dest_we`, `dflt_valid` and `dflt_data` are combinational in the cycle an operation is presented. Cause, flag and CPU-written values show on `csr_rdata` one clock edge later. The bench drives each stimulus on a falling edge and reads the combinational outputs one nanosecond later, before the rising edge. It then reads the register at the following falling edge, after exactly one register stage. A bench-side model of the three fields is updated from the requirements and gives the expected readback after every step.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NSRC   = 5;
    localparam int NCAUSE = NSRC + 1;
    localparam int CSR_W  = NCAUSE + 2 * NSRC;

    localparam int SRC_I = 0;
    localparam int SRC_U = 1;
    localparam int SRC_O = 2;
    localparam int SRC_Z = 3;
    localparam int SRC_V = 4;
    localparam int CAUSE_E = NSRC;

    // Sources whose trap may be taken on mere possibility
    localparam logic [NSRC-1:0] POSSIBLE_MASK = 5'b00111;

    typedef struct packed {
        logic [NCAUSE-1:0] cause;
        logic [NSRC-1:0]   enable;
        logic [NSRC-1:0]   flag;
    } fpx_csr_t;

    typedef enum logic [1:0] {
        DFLT_NONE = 2'd0,
        DFLT_QNAN = 2'd1,
        DFLT_INF  = 2'd2
    } fpx_dflt_e;

    function automatic logic [NSRC-1:0] sticky_merge(input logic [NSRC-1:0] old_f,
                                                     input logic [NSRC-1:0] hit);
        return old_f | hit;
    endfunction

endpackage

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide
    import fpx_pkg::*;
(
    input  logic              op_valid,
    input  logic              dn_mode,
    input  logic              ev_denorm,
    input  logic [NSRC-1:0]   ev_src,
    input  logic [NSRC-1:0]   may_src,
    input  logic              op_xform,
    input  logic [NSRC-1:0]   enable,
    output logic [NCAUSE-1:0] cause_new,
    output logic              trap
);

    logic [NSRC-1:0] src_applies;
    logic [NSRC-1:0] src_trap;
    logic            err_hit;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            if (POSSIBLE_MASK[g]) begin : g_poss
                assign src_applies[g] = ev_src[g] | may_src[g];
            end else if (g == SRC_V) begin : g_inv
                assign src_applies[g] = ev_src[g] | op_xform;
            end else begin : g_plain
                assign src_applies[g] = ev_src[g];
            end
            assign src_trap[g] = enable[g] & src_applies[g];
        end
    endgenerate

    assign err_hit   = ev_denorm & ~dn_mode;
    assign cause_new = {err_hit, ev_src};
    assign trap      = op_valid & (err_hit | (|src_trap));

endmodule

// File: rtl/fpx_default_gen.sv
module fpx_default_gen
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic            op_valid,
    input  logic            trap,
    input  logic [NSRC-1:0] ev_src,
    input  logic            res_sign,
    output logic            dflt_valid,
    output logic [FP_W-1:0] dflt_data
);

    localparam logic [FP_W-1:0] QNAN_PAT =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FP_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    fpx_dflt_e kind;

    always_comb begin
        kind = DFLT_NONE;
        if (op_valid && !trap) begin
            if (ev_src[SRC_V])      kind = DFLT_QNAN;
            else if (ev_src[SRC_Z]) kind = DFLT_INF;
        end
    end

    always_comb begin
        unique case (kind)
            DFLT_QNAN: dflt_data = QNAN_PAT;
            DFLT_INF:  dflt_data = {res_sign, INF_MAG};
            default:   dflt_data = '0;
        endcase
    end

    assign dflt_valid = (kind != DFLT_NONE);

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [NCAUSE-1:0] cause_new,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    output fpx_csr_t          csr_q
);

    fpx_csr_t csr_d;

    always_comb begin
        csr_d = csr_q;
        if (csr_we) begin
            csr_d = fpx_csr_t'(csr_wdata);
        end else if (op_valid) begin
            csr_d.cause = cause_new;
            csr_d.flag  = sticky_merge(csr_q.flag, cause_new[NSRC-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) csr_q <= '0;
        else     csr_q <= csr_d;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> ((csr_q.flag & $past(csr_q.flag)) == $past(csr_q.flag))) else $error("flag lost"); // R3
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!csr_we && !op_valid) |=> $stable(csr_q.cause)) else $error("cause moved"); // R2
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> $stable(csr_q.enable)) else $error("enable moved"); // R10

endmodule

// File: rtl/fp_exc_unit.sv
module fp_exc_unit
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             dn_mode,
    input  logic             ev_denorm,
    input  logic [NSRC-1:0]  ev_src,
    input  logic [NSRC-1:0]  may_src,
    input  logic             op_xform,
    input  logic             res_sign,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             trap_req,
    output logic             dest_we,
    output logic             dflt_valid,
    output logic [FP_W-1:0]  dflt_data
);

    fpx_csr_t          csr_q;
    logic [NCAUSE-1:0] cause_new;
    logic              trap;

    fpx_trap_decide u_decide (
        .op_valid (op_valid),
        .dn_mode  (dn_mode),
        .ev_denorm(ev_denorm),
        .ev_src   (ev_src),
        .may_src  (may_src),
        .op_xform (op_xform),
        .enable   (csr_q.enable),
        .cause_new(cause_new),
        .trap     (trap)
    );

    fpx_status_reg u_csr (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .cause_new(cause_new),
        .csr_we   (csr_we),
        .csr_wdata(csr_wdata),
        .csr_q    (csr_q)
    );

    fpx_default_gen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dflt (
        .op_valid  (op_valid),
        .trap      (trap),
        .ev_src    (ev_src),
        .res_sign  (res_sign),
        .dflt_valid(dflt_valid),
        .dflt_data (dflt_data)
    );

    assign csr_rdata = csr_q;
    assign trap_req  = trap;
    assign dest_we   = op_valid & ~trap;

    AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (!dest_we && !dflt_valid)) else $error("write during trap"); // R7
    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !trap_req) else $error("trap while idle"); // R7
    AST_ERROR_UNMASKABLE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ev_denorm && !dn_mode) |-> trap_req) else $error("error masked"); // R4
    AST_ERROR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !csr_we) |=> (csr_rdata[CSR_W-1] == $past(ev_denorm && !dn_mode))) else $error("error cause"); // R4
    AST_DFLT_NAN: assert property (@(posedge clk) disable iff (rst)
        (dflt_valid && ev_src[SRC_V]) |-> (dflt_data[FP_W-2 -: EXP_W+1] == {(EXP_W+1){1'b1}})) else $error("nan pattern"); // R8

endmodule

// File: tb/tb_fp_exc_unit.sv
module tb_fp_exc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, dn_mode, ev_denorm, op_xform, res_sign, csr_we;
    logic [4:0]  ev_src, may_src;
    logic [15:0] csr_wdata, csr_rdata;
    logic        trap_req, dest_we, dflt_valid;
    logic [31:0] dflt_data;

    int total = 0;
    int bad   = 0;

    // bench model of the register fields
    logic [5:0] m_cause;
    logic [4:0] m_en, m_flag;

    always #4 clk = ~clk;

    fp_exc_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .dn_mode(dn_mode),
        .ev_denorm(ev_denorm), .ev_src(ev_src), .may_src(may_src),
        .op_xform(op_xform), .res_sign(res_sign), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trap_req(trap_req),
        .dest_we(dest_we), .dflt_valid(dflt_valid), .dflt_data(dflt_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_reg();
        return {m_cause, m_en, m_flag};
    endfunction

    task automatic csr_write(input logic [15:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
        m_cause = v[15:10]; m_en = v[9:5]; m_flag = v[4:0];
    endtask

    // present one operation; check combinational outputs, then the register
    task automatic do_op(input string req, input logic dn, input logic dnrm,
                         input logic [4:0] ev, input logic [4:0] may,
                         input logic xf, input logic sg,
                         input logic exp_trap, input logic exp_dv,
                         input logic [31:0] exp_dd);
        @(negedge clk);
        op_valid = 1'b1; dn_mode = dn; ev_denorm = dnrm; ev_src = ev;
        may_src = may; op_xform = xf; res_sign = sg;
        #1;
        check({req, " trap"}, 32'(trap_req), 32'(exp_trap));
        check({req, " dest_we"}, 32'(dest_we), 32'(!exp_trap));
        check({req, " dflt_valid"}, 32'(dflt_valid), 32'(exp_dv));
        if (exp_dv) check({req, " dflt_data"}, dflt_data, exp_dd);
        @(negedge clk);
        op_valid = 1'b0; ev_src = '0; may_src = '0; ev_denorm = 1'b0; op_xform = 1'b0;
        m_cause = {dnrm & ~dn, ev};
        m_flag  = m_flag | ev;
        check({req, " csr"}, 32'(csr_rdata), 32'(model_reg()));
    endtask

    task automatic t_reset();
        check("R1 reset csr", 32'(csr_rdata), 32'h0);
        check("R7 idle trap", 32'(trap_req), 32'h0);
    endtask

    task automatic t_cause_flag();
        do_op("R2 R3 invalid", 1'b1, 1'b0, 5'b10000, 5'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h7FC00000);
        do_op("R2 R3 inexact", 1'b1, 1'b0, 5'b00001, 5'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R3 flag sticky", 32'(csr_rdata[4:0]), 32'h11);
        check("R2 cause latest", 32'(csr_rdata[15:10]), 32'h01);
        repeat (2) @(negedge clk);
        check("R2 cause hold idle", 32'(csr_rdata), 32'(model_reg()));
    endtask

    task automatic t_denorm();
        do_op("R4 denorm trap", 1'b0, 1'b1, 5'b0, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        check("R4 error cause bit15", 32'(csr_rdata[15]), 32'h1);
        do_op("R4 flushed no error", 1'b1, 1'b1, 5'b0, 5'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_enable();
        csr_write({6'b0, 5'b01000, 5'b0});   // enable divide-by-zero
        do_op("R5 Z enabled", 1'b1, 1'b0, 5'b01000, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        do_op("R5 I not enabled", 1'b1, 1'b0, 5'b00001, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        csr_write({6'b0, 5'b00100, 5'b0});   // enable overflow
        do_op("R6 O possible only", 1'b1, 1'b0, 5'b0, 5'b00100, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        check("R6 no cause", 32'(csr_rdata[15:10]), 32'h0);
        csr_write({6'b0, 5'b10000, 5'b0});   // enable invalid
        do_op("R6 xform trap", 1'b1, 1'b0, 5'b0, 5'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
        do_op("R5 V no event", 1'b1, 1'b0, 5'b0, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_defaults();
        csr_write(16'h0);
        do_op("R9 inf neg", 1'b1, 1'b0, 5'b01000, 5'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'hFF800000);
        do_op("R9 inf pos", 1'b1, 1'b0, 5'b01000, 5'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h7F800000);
        do_op("R8 nan over inf", 1'b1, 1'b0, 5'b11000, 5'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h7FC00000);
    endtask

    task automatic t_priority();
        @(negedge clk);
        op_valid = 1'b1; dn_mode = 1'b0; ev_denorm = 1'b1; ev_src = 5'b11111;
        csr_we = 1'b1; csr_wdata = 16'h02A0;
        @(negedge clk);
        op_valid = 1'b0; csr_we = 1'b0; ev_src = '0; ev_denorm = 1'b0;
        check("R10 write wins", 32'(csr_rdata), 32'h02A0);
        m_cause = 6'h0; m_en = 5'b10101; m_flag = 5'h0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; dn_mode = 1'b1; ev_denorm = 1'b0;
        ev_src = '0; may_src = '0; op_xform = 1'b0; res_sign = 1'b0;
        csr_we = 1'b0; csr_wdata = '0;
        m_cause = '0; m_en = '0; m_flag = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cause_flag();
        t_denorm();
        t_enable();
        t_defaults();
        t_priority();
        csr_write(16'h0);
        check("R10 clear readback", 32'(csr_rdata), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule